// File: doc/BRIEF.md
# Power Stage Protection Status Logic

This block is the digital protection core of a four-half-bridge switching power stage. Synchronized comparator flags come in as plain digital levels: an overcurrent flag for the high-side and the low-side device of every half-bridge, plus shared flags for over-temperature warning, over-temperature error and undervoltage. The block decides, for each pair of half-bridges, whether that pair may switch or must be held in high-impedance. It also drives two active-low, open-drain style status levels to a supervising controller.

An active-low reset pin does two jobs. It mutes the stage by forcing high-impedance without recording an error. Its falling edge also clears any latched error. Two mode pins choose how errors are handled. In latching mode an error holds the affected pair off until the reset pin is toggled. In autorecovery mode the pair restarts by itself once the error has gone and a fixed number of rising edges has been seen on the PWM input. A test mode ignores all protection flags.

Each bridge pair has its own state machine with four states. MUTE is entered whenever the reset pin is low, and is also the power-on state. RUN means the pair is switching. LATCHED is a held fault. AR_WAIT is an autorecovery countdown. The named transitions are: release (MUTE to RUN when no error is present), trip_latch (RUN or MUTE to LATCHED on an error in latching mode), trip_ar (RUN or MUTE to AR_WAIT on an error in autorecovery mode), ar_done (AR_WAIT to RUN once the count is spent and no error is present), and mute (any state to MUTE when the reset pin is low). An overcurrent on a bridge trips only the pair that contains that bridge. Over-temperature error and undervoltage trip every pair.

Top module: `prot_status_core`

## Requirements
- R1: After the asynchronous chip reset, with the reset pin low and all flags clear, both bits of `hiz` read 1, and `sd_n` and `otw_n` read 1.
- R2: When the reset pin goes high with no error flag set, both pairs stop being high-impedance (`hiz` = 00) after the next clock edge, and `sd_n` stays 1.
- R3: While the reset pin is low, `hiz` reads 11 and `sd_n` reads 1 in the same cycle, whatever error is latched. A low reset pin also clears any latched error, including an over-temperature cause held on `otw_n`.
- R4: An overcurrent flag (`oc_hi` or `oc_lo`) on bridge b sets `hiz[b/2]` after the next clock edge. Bridges 0 and 1 form pair 0, and bridges 2 and 3 form pair 1. The other pair keeps switching.
- R5: `ote_flag` or `uv_flag` sets both bits of `hiz` after the next clock edge.
- R6: In latching mode (`mode_sel` 01, with code 11 treated the same way), a tripped pair stays high-impedance after its flags clear, until the reset pin has been low for at least one clock edge and is high again.
- R7: If an error flag is set when the reset pin rises, the affected pair goes to a fault state instead of switching.
- R8: In autorecovery mode (`mode_sel` 00), after the flags clear, a tripped pair resumes on the clock edge after the one that counts the AR_EDGES-th rising edge of `pwm_in`. After AR_EDGES-1 rising edges it is still high-impedance.
- R9: In autorecovery mode, any error flag seen during the countdown restarts the count at AR_EDGES.
- R10: In protection-disabled mode (`mode_sel` 10), the error flags have no effect. `hiz` follows only the reset pin, and `sd_n` stays 1.
- R11: `sd_n` reads 0 while the reset pin is high and any pair is in LATCHED or AR_WAIT.
- R12: The status pair (`otw_n`, `sd_n`) reads 00 for a fault caused by over-temperature error (held while the fault lasts), 10 for a fault caused only by overcurrent or undervoltage, 01 when only `otw_flag` is set, and 11 in normal operation. `otw_n` follows `otw_flag` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Reset/mute pin, active low; a low level clears latched errors |
| mode_sel | input | 2 | Protection mode: 00 autorecovery, 01 latching, 10 disabled, 11 latching |
| pwm_in | input | 1 | PWM input level; its rising edges time autorecovery |
| oc_hi | input | 4 | Overcurrent flag of each high-side device, one bit per bridge |
| oc_lo | input | 4 | Overcurrent flag of each low-side device, one bit per bridge |
| otw_flag | input | 1 | Shared over-temperature warning flag |
| ote_flag | input | 1 | Shared over-temperature error flag |
| uv_flag | input | 1 | Shared undervoltage flag |
| hiz | output | 2 | High-impedance command per bridge pair |
| sd_n | output | 1 | Shutdown status, active low |
| otw_n | output | 1 | Temperature warning status, active low |

## Verification
The assertions assume that every flag and pin is already synchronous to `clk`. They also assume that `mode_sel` changes only while the reset pin holds the stage in MUTE, so the autorecovery, latching and disabled behaviours are never mixed inside one fault episode. The stimulus drives every input just after a falling clock edge. It changes `mode_sel` only inside a reset-pin low phase. It toggles `pwm_in` with at least one clock in each level, so every rising edge is seen by exactly one clock edge.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        ST_MUTE,
        ST_RUN,
        ST_LATCHED,
        ST_AR_WAIT
    } pair_state_e;

    typedef enum logic [1:0] {
        PM_AUTO,
        PM_LATCH,
        PM_OFF
    } prot_mode_e;

endpackage

// File: rtl/prot_mode_dec.sv
module prot_mode_dec
    import prot_pkg::*;
(
    input  logic [1:0]  mode_sel,
    output prot_mode_e  mode
);

    always_comb begin
        unique case (mode_sel)
            2'b00:   mode = PM_AUTO;
            2'b01:   mode = PM_LATCH;
            2'b10:   mode = PM_OFF;
            default: mode = PM_LATCH;   // unassigned code fails safe
        endcase
    end

endmodule

// File: rtl/prot_pair_fsm.sv
module prot_pair_fsm
    import prot_pkg::*;
#(
    parameter int AR_EDGES = 4096
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        run_req,
    input  prot_mode_e  mode,
    input  logic        err_oc,
    input  logic        err_ote,
    input  logic        err_uv,
    input  logic        pwm_rise,
    output logic        drive_off,
    output logic        faulted,
    output logic        ot_cause
);

    localparam int CW = $clog2(AR_EDGES + 1);
    localparam logic [CW-1:0] AR_LOAD = CW'(AR_EDGES);

    pair_state_e   state, state_nx;
    logic [CW-1:0] ar_cnt;
    logic          err_any;
    logic          nx_fault;
    pair_state_e   trip_target;

    assign err_any     = (mode != PM_OFF) && (err_oc || err_ote || err_uv);
    assign trip_target = (mode == PM_AUTO) ? ST_AR_WAIT : ST_LATCHED;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_MUTE:    state_nx = err_any ? trip_target : ST_RUN;   // release / trip
            ST_RUN:     if (err_any) state_nx = trip_target;         // trip_latch / trip_ar
            ST_LATCHED: state_nx = ST_LATCHED;
            ST_AR_WAIT: if (!err_any && ar_cnt == '0) state_nx = ST_RUN;  // ar_done
            default:    state_nx = ST_MUTE;
        endcase
        if (!run_req) state_nx = ST_MUTE;                            // mute
    end

    assign nx_fault = (state_nx == ST_LATCHED) || (state_nx == ST_AR_WAIT);

    // state register, countdown and fault cause
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state    <= ST_MUTE;
            ar_cnt   <= '0;
            ot_cause <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_AR_WAIT && (state != ST_AR_WAIT || err_any))
                ar_cnt <= AR_LOAD;
            else if (state == ST_AR_WAIT && pwm_rise && ar_cnt != '0)
                ar_cnt <= ar_cnt - 1'b1;
            if (nx_fault)
                ot_cause <= (faulted && ot_cause) || (err_any && err_ote);
            else
                ot_cause <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        drive_off = (state != ST_RUN);
        faulted   = (state == ST_LATCHED) || (state == ST_AR_WAIT);
    end

    p_mute_on_pin_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !run_req |=> state == ST_MUTE);

    p_trip_from_run_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RUN && run_req && err_any) |=> (state == ST_LATCHED || state == ST_AR_WAIT));

    p_latch_holds_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_LATCHED && run_req) |=> state == ST_LATCHED);

    p_no_early_exit_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_AR_WAIT && ar_cnt != '0) |=> state != ST_RUN);

    p_reload_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_AR_WAIT && run_req && err_any) |=> ar_cnt == AR_LOAD);

    p_off_no_trip_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RUN && run_req && mode == PM_OFF) |=> state == ST_RUN);

endmodule

// File: rtl/prot_status_enc.sv
module prot_status_enc #(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 rst_pin_n,
    input  logic [NUM_PAIRS-1:0] faulted,
    input  logic [NUM_PAIRS-1:0] ot_cause,
    input  logic                 otw_flag,
    output logic                 sd_n,
    output logic                 otw_n
);

    always_comb begin
        sd_n  = !rst_pin_n || !(|faulted);
        otw_n = !(otw_flag || (rst_pin_n && |(faulted & ot_cause)));
    end

endmodule

// File: rtl/prot_status_core.sv
module prot_status_core
    import prot_pkg::*;
#(
    parameter int NUM_BRIDGES = 4,
    parameter int AR_EDGES    = 4096
) (
    input  logic                   clk,
    input  logic                   arst_n,
    input  logic                   rst_pin_n,
    input  logic [1:0]             mode_sel,
    input  logic                   pwm_in,
    input  logic [NUM_BRIDGES-1:0] oc_hi,
    input  logic [NUM_BRIDGES-1:0] oc_lo,
    input  logic                   otw_flag,
    input  logic                   ote_flag,
    input  logic                   uv_flag,
    output logic [NUM_BRIDGES/2-1:0] hiz,
    output logic                   sd_n,
    output logic                   otw_n
);

    localparam int NUM_PAIRS = NUM_BRIDGES / 2;

    prot_mode_e           mode;
    logic                 pwm_q;
    logic                 pwm_rise;
    logic [NUM_PAIRS-1:0] drive_off;
    logic [NUM_PAIRS-1:0] faulted;
    logic [NUM_PAIRS-1:0] ot_cause;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pwm_q <= 1'b0;
        else         pwm_q <= pwm_in;
    end

    assign pwm_rise = pwm_in && !pwm_q;

    prot_mode_dec u_mode (
        .mode_sel (mode_sel),
        .mode     (mode)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic pair_oc;
        assign pair_oc = |{oc_hi[2*p+1], oc_hi[2*p], oc_lo[2*p+1], oc_lo[2*p]};

        prot_pair_fsm #(.AR_EDGES(AR_EDGES)) u_fsm (
            .clk       (clk),
            .arst_n    (arst_n),
            .run_req   (rst_pin_n),
            .mode      (mode),
            .err_oc    (pair_oc),
            .err_ote   (ote_flag),
            .err_uv    (uv_flag),
            .pwm_rise  (pwm_rise),
            .drive_off (drive_off[p]),
            .faulted   (faulted[p]),
            .ot_cause  (ot_cause[p])
        );

        assign hiz[p] = !rst_pin_n || drive_off[p];
    end

    prot_status_enc #(.NUM_PAIRS(NUM_PAIRS)) u_enc (
        .rst_pin_n (rst_pin_n),
        .faulted   (faulted),
        .ot_cause  (ot_cause),
        .otw_flag  (otw_flag),
        .sd_n      (sd_n),
        .otw_n     (otw_n)
    );

    p_shared_all_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_pin_n && (ote_flag || uv_flag) && mode != PM_OFF) |=> &hiz);

    p_sd_reports_r11: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_pin_n && $past(rst_pin_n) && (|faulted)) |-> !sd_n);

endmodule

// File: tb/test_prot_status_core.sv
module test_prot_status_core;

    localparam int NB = 4;
    localparam int AR = 4096;

    logic          clk = 1'b0;
    logic          arst_n = 1'b0;
    logic          rst_pin_n = 1'b0;
    logic [1:0]    mode_sel = 2'b01;
    logic          pwm_in = 1'b0;
    logic [NB-1:0] oc_hi = '0;
    logic [NB-1:0] oc_lo = '0;
    logic          otw_flag = 1'b0;
    logic          ote_flag = 1'b0;
    logic          uv_flag = 1'b0;
    logic [NB/2-1:0] hiz;
    logic          sd_n;
    logic          otw_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    prot_status_core #(.NUM_BRIDGES(NB), .AR_EDGES(AR)) i_prot_status_core (
        .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .mode_sel(mode_sel),
        .pwm_in(pwm_in), .oc_hi(oc_hi), .oc_lo(oc_lo), .otw_flag(otw_flag),
        .ote_flag(ote_flag), .uv_flag(uv_flag), .hiz(hiz), .sd_n(sd_n), .otw_n(otw_n)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pwm_in = 1'b1; step(1);
            pwm_in = 1'b0; step(1);
        end
    endtask

    task automatic toggle_pin(input logic [1:0] new_mode);
        rst_pin_n = 1'b0; mode_sel = new_mode; step(1);
        rst_pin_n = 1'b1; step(1);
    endtask

    task automatic t_reset;
        chk("R1 hiz", 8'(hiz), 8'h3);
        chk("R1 sd_n", 8'(sd_n), 8'h1);
        chk("R1 otw_n", 8'(otw_n), 8'h1);
    endtask

    task automatic t_release;
        rst_pin_n = 1'b1; step(1);
        chk("R2 hiz", 8'(hiz), 8'h0);
        chk("R2 sd_n", 8'(sd_n), 8'h1);
    endtask

    task automatic t_oc_pair;
        oc_lo[3] = 1'b1; step(1);
        chk("R4 oc_lo3 hiz", 8'(hiz), 8'h2);
        chk("R11 sd_n", 8'(sd_n), 8'h0);
        chk("R12 oc code", 8'({otw_n, sd_n}), 8'h2);
        oc_lo[3] = 1'b0;
        rst_pin_n = 1'b0; #1;
        chk("R3 hiz mute", 8'(hiz), 8'h3);
        chk("R3 sd_n mute", 8'(sd_n), 8'h1);
        step(1); rst_pin_n = 1'b1; step(1);
        chk("R3 latch cleared", 8'(hiz), 8'h0);
        oc_hi[0] = 1'b1; step(1);
        chk("R4 oc_hi0 hiz", 8'(hiz), 8'h1);
        oc_hi[0] = 1'b0; toggle_pin(2'b01);
    endtask

    task automatic t_shared;
        uv_flag = 1'b1; step(1);
        chk("R5 uv hiz", 8'(hiz), 8'h3);
        chk("R12 uv code", 8'({otw_n, sd_n}), 8'h2);
        uv_flag = 1'b0; step(3);
        chk("R6 latched hiz", 8'(hiz), 8'h3);
        toggle_pin(2'b01);
        chk("R6 after toggle", 8'(hiz), 8'h0);
    endtask

    task automatic t_release_err;
        rst_pin_n = 1'b0; step(1);
        oc_hi[1] = 1'b1; rst_pin_n = 1'b1; step(1);
        chk("R7 hiz", 8'(hiz), 8'h1);
        oc_hi[1] = 1'b0; step(1);
        chk("R7 still held", 8'(hiz), 8'h1);
        toggle_pin(2'b01);
        chk("R7 after toggle", 8'(hiz), 8'h0);
    endtask

    task automatic t_latch_code11;
        toggle_pin(2'b11);
        ote_flag = 1'b1; step(1);
        chk("R5 ote hiz", 8'(hiz), 8'h3);
        chk("R12 ote code", 8'({otw_n, sd_n}), 8'h0);
        ote_flag = 1'b0; step(2);
        chk("R6 code11 held", 8'(hiz), 8'h3);
        chk("R12 ote held code", 8'({otw_n, sd_n}), 8'h0);
        rst_pin_n = 1'b0; #1;
        chk("R3 mute code", 8'({otw_n, sd_n}), 8'h3);
        step(1); rst_pin_n = 1'b1; step(1);
        chk("R3 code11 cleared", 8'(hiz), 8'h0);
    endtask

    task automatic t_warn;
        otw_flag = 1'b1; #1;
        chk("R12 warn code", 8'({otw_n, sd_n}), 8'h1);
        step(1);
        chk("R12 warn keeps run", 8'(hiz), 8'h0);
        otw_flag = 1'b0; #1;
        chk("R12 normal code", 8'({otw_n, sd_n}), 8'h3);
        step(1);
    endtask

    task automatic t_auto;
        toggle_pin(2'b00);
        oc_hi[2] = 1'b1; step(1);
        chk("R8 trip", 8'(hiz), 8'h2);
        oc_hi[2] = 1'b0; step(1);
        pulses(AR - 1);
        chk("R8 one edge short", 8'(hiz), 8'h2);
        pulses(1);
        chk("R8 resumed", 8'(hiz), 8'h0);
        chk("R8 sd_n", 8'(sd_n), 8'h1);
    endtask

    task automatic t_restart;
        uv_flag = 1'b1; step(1);
        uv_flag = 1'b0; step(1);
        pulses(100);
        uv_flag = 1'b1; step(1);
        uv_flag = 1'b0; step(1);
        pulses(AR - 1);
        chk("R9 restarted count", 8'(hiz), 8'h3);
        pulses(1);
        chk("R9 resumed", 8'(hiz), 8'h0);
    endtask

    task automatic t_disabled;
        toggle_pin(2'b10);
        oc_hi = '1; oc_lo = '1; ote_flag = 1'b1; uv_flag = 1'b1; step(2);
        chk("R10 hiz", 8'(hiz), 8'h0);
        chk("R10 sd_n", 8'(sd_n), 8'h1);
        rst_pin_n = 1'b0; #1;
        chk("R10 pin mute", 8'(hiz), 8'h3);
        oc_hi = '0; oc_lo = '0; ote_flag = 1'b0; uv_flag = 1'b0;
        step(1); rst_pin_n = 1'b1; step(1);
        chk("R10 pin release", 8'(hiz), 8'h0);
    endtask

    initial begin
        step(3);
        arst_n = 1'b1;
        step(1);
        t_reset();
        t_release();
        t_oc_pair();
        t_shared();
        t_release_err();
        t_latch_code11();
        t_warn();
        t_auto();
        t_restart();
        t_disabled();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule